// File: doc/BRIEF.md
# Pseudo-Random Link Test Packet Source

This block feeds a link self-test with an endless stream of packets. Each packet is a run of 32-bit payload words taken from a free-running pseudo-random sequence, closed by one CRC word. Between packets the stream is idle for a number of cycles. Both the payload length and the idle gap are either fixed or random, and in random mode the programmed field acts as a bit mask on the random value. Its inputs are control levels of the kind a register block would drive. Its outputs are a word stream with first-word and last-word markers.

The stream runs only while the test-mode enable and the start control are both high and no error has been seen. An error on any of the three error inputs stops the stream until start or test mode is dropped. For fault injection, the CRC word can be fully inverted, or only its least significant bit can be flipped. A receiving checker can then confirm that it rejects the packet.

Top module: `pkt_traffic_gen`

## Requirements
- R1: After reset, and whenever `test_en` or `tx_start` is low, `tx_valid`, `tx_sop` and `tx_eop` stay low.
- R2: If `test_en` or `tx_start` is low at a clock edge, `tx_valid` is low from that edge on. No further word of the interrupted packet appears.
- R3: If any of `rx_mismatch`, `link_pkt_err` or `data_pkt_err` is high at an edge, `tx_valid` is low from that edge on and stays low while `test_en` and `tx_start` remain high. After `tx_start` has been low for at least one edge, setting it again starts a new packet on the next edge.
- R4: A packet is L payload words, with `tx_sop` on the first, followed by one CRC word with `tx_eop`. In fixed mode (`rand_len_en`=0), L = `len_field` + 3.
- R5: In random mode, L = (r[10:0] AND `len_field`) + 3. Here r is the length generator value when the packet starts.
- R6: After the CRC word, the stream is idle for G cycles and then the next `tx_sop` follows. G = `gap_field` + 2 in fixed mode and (r[22:16] AND `gap_field`) + 2 in random mode, using the same r as the packet's length.
- R7: Payload words come from a 32-bit LFSR with next = {s[30:0],0} XOR (s[31] ? 0x00400007 : 0). It is loaded with 0xC0DE0001 while `test_en` is low and advances once per payload word, so the first word after enabling is 0xC0DE0001.
- R8: The CRC word is the reflected CRC-32 of the packet's payload words: polynomial 0xEDB88320, initial value all ones, bit 0 of each word first, result complemented.
- R9: With `crc_invert_all` high when the CRC word is emitted, every bit of that word is inverted.
- R10: With `crc_flip_lsb` high when the CRC word is emitted, bit 0 of that word is inverted. This applies on top of R9.
- R11: `len_field`, `gap_field` and the random-enable bits are sampled only on the edge that emits `tx_sop`. A change during a packet first affects the next packet.
- R12: The length generator r uses the R7 recurrence. It is loaded with 0x13579BDF while `test_en` is low and advances once per packet start, in both fixed and random mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Test-mode enable; low reloads both generators |
| tx_start | input | 1 | Start control; low stops and clears a halt |
| rand_len_en | input | 1 | 1 = random payload length |
| len_field | input | 11 | Length value or mask |
| rand_gap_en | input | 1 | 1 = random idle gap |
| gap_field | input | 7 | Gap value or mask |
| crc_invert_all | input | 1 | Invert the whole CRC word |
| crc_flip_lsb | input | 1 | Invert bit 0 of the CRC word |
| rx_mismatch | input | 1 | Error: received data mismatch |
| link_pkt_err | input | 1 | Error: link-level packet error |
| data_pkt_err | input | 1 | Error: transaction packet error |
| tx_valid | output | 1 | Output word valid |
| tx_sop | output | 1 | First payload word of a packet |
| tx_eop | output | 1 | CRC word, last of a packet |
| tx_data | output | 32 | Output word |

## Verification
The assertions assume that every control, field and error input is synchronous to `clk` and is only ever seen settled at a rising edge. They also assume reset is held over the first edges, so that the generator states are never sampled before they are loaded. The bench keeps to this by changing inputs only on falling edges and by holding reset for several cycles at time zero. It runs each scenario from a freshly reloaded generator pair, so that its own model of both LFSRs and of the CRC stays aligned with the stream.

// File: rtl/pkt_gen_pkg.sv
package pkt_gen_pkg;
  localparam int          DATA_W    = 32;
  localparam int          LEN_OFS   = 3;
  localparam int          GAP_OFS   = 2;
  localparam int          GAP_LSB   = 16;
  localparam logic [31:0] LFSR_TAPS = 32'h0040_0007;
  localparam logic [31:0] PAY_SEED  = 32'hC0DE_0001;
  localparam logic [31:0] RNG_SEED  = 32'h1357_9BDF;
  localparam logic [31:0] CRC_POLY  = 32'hEDB8_8320;

  localparam logic        DEF_RAND_LEN = 1'b1;
  localparam logic [10:0] DEF_LEN      = 11'h1FF;
  localparam logic        DEF_RAND_GAP = 1'b1;
  localparam logic [6:0]  DEF_GAP      = 7'h1F;
  localparam logic        DEF_START    = 1'b1;
  localparam logic        DEF_TEST_EN  = 1'b0;

  typedef enum logic [1:0] {ST_IDLE, ST_PAY, ST_CRC, ST_GAP} seq_state_t;

  function automatic logic [31:0] crc32_word(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c ^ d;
    for (int b = 0; b < 32; b++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/pkt_lfsr.sv
module pkt_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = 32'h0040_0007,
  parameter logic [W-1:0] SEED = 32'h0000_0001
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reload,
  input  logic         adv,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || reload) begin
      q <= SEED;
    end else if (adv) begin
      q <= {q[W-2:0], 1'b0} ^ (q[W-1] ? TAPS : '0);
    end
  end

  assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (rst) q != '0)
    else $error("LFSR reached the all-zero lock-up state");
endmodule

// File: rtl/pkt_crc32.sv
module pkt_crc32
  import pkt_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  input  logic [DATA_W-1:0] din,
  output logic [31:0]       crc_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc_q <= '1;
    end else if (adv) begin
      crc_q <= crc32_word(crc_q, din);
    end
  end
endmodule

// File: rtl/pkt_seq.sv
module pkt_seq
  import pkt_gen_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int GAP_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_en,
  input  logic              start,
  input  logic              err_any,
  input  logic              rand_len_en,
  input  logic [LEN_W-1:0]  len_field,
  input  logic              rand_gap_en,
  input  logic [GAP_W-1:0]  gap_field,
  input  logic              inv_all,
  input  logic              flip_lsb,
  input  logic [DATA_W-1:0] pay_word,
  input  logic [31:0]       rng_word,
  input  logic [31:0]       crc_word,
  output logic              pay_adv,
  output logic              rng_adv,
  output logic              crc_clr,
  output logic              crc_adv,
  output logic              o_valid,
  output logic              o_sop,
  output logic              o_eop,
  output logic [DATA_W-1:0] o_data
);
  localparam int CNT_W = LEN_W + 1;
  localparam int GCN_W = GAP_W + 1;

  seq_state_t       st;
  logic             halted;
  logic [CNT_W-1:0] rem_cnt;
  logic [GCN_W-1:0] gap_cnt;
  logic [GCN_W-1:0] gap_hold;

  logic             run;
  logic             start_pkt;
  logic             emit_pay;
  logic             emit_crc;
  logic [LEN_W-1:0] len_base;
  logic [GAP_W-1:0] gap_base;
  logic [CNT_W-1:0] len_pick;
  logic [GCN_W-1:0] gap_pick;
  logic [31:0]      crc_out;
  logic             unused_rng;

  assign unused_rng = ^rng_word;

  assign run       = test_en && start && !halted && !err_any;
  assign start_pkt = run && ((st == ST_IDLE) || (st == ST_GAP && gap_cnt == '0));
  assign emit_pay  = run && (st == ST_PAY);
  assign emit_crc  = run && (st == ST_CRC);

  assign pay_adv = start_pkt || emit_pay;
  assign crc_adv = pay_adv;
  assign rng_adv = start_pkt;
  assign crc_clr = emit_crc || !run;

  assign len_base = rand_len_en ? (rng_word[LEN_W-1:0] & len_field) : len_field;
  assign gap_base = rand_gap_en ? (rng_word[GAP_LSB +: GAP_W] & gap_field) : gap_field;
  assign len_pick = {1'b0, len_base} + CNT_W'(LEN_OFS);
  assign gap_pick = {1'b0, gap_base} + GCN_W'(GAP_OFS);

  assign crc_out = ~crc_word ^ {32{inv_all}} ^ {31'd0, flip_lsb};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      halted   <= 1'b0;
      rem_cnt  <= '0;
      gap_cnt  <= '0;
      gap_hold <= '0;
      o_valid  <= 1'b0;
      o_sop    <= 1'b0;
      o_eop    <= 1'b0;
      o_data   <= '0;
    end else begin
      halted  <= (halted || err_any) && test_en && start;
      o_valid <= 1'b0;
      o_sop   <= 1'b0;
      o_eop   <= 1'b0;
      o_data  <= '0;
      if (!run) begin
        st <= ST_IDLE;
      end else if (start_pkt) begin
        o_valid  <= 1'b1;
        o_sop    <= 1'b1;
        o_data   <= pay_word;
        rem_cnt  <= len_pick - CNT_W'(1);
        gap_hold <= gap_pick;
        st       <= ST_PAY;
      end else begin
        case (st)
          ST_PAY: begin
            o_valid <= 1'b1;
            o_data  <= pay_word;
            rem_cnt <= rem_cnt - CNT_W'(1);
            if (rem_cnt == CNT_W'(1)) st <= ST_CRC;
          end
          ST_CRC: begin
            o_valid <= 1'b1;
            o_eop   <= 1'b1;
            o_data  <= crc_out;
            gap_cnt <= gap_hold;
            st      <= ST_GAP;
          end
          ST_GAP: begin
            gap_cnt <= gap_cnt - GCN_W'(1);
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assert_off_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !(test_en && start) |=> !o_valid)
    else $error("word emitted after test mode or start dropped");

  assert_err_stop_R3: assert property (@(posedge clk) disable iff (rst)
    err_any |=> !o_valid)
    else $error("word emitted after an error input");

  assert_sop_frame_R4: assert property (@(posedge clk) disable iff (rst)
    o_sop |-> (o_valid && !o_eop))
    else $error("first-word marker without valid or with last-word marker");

  assert_len_bound_R5: assert property (@(posedge clk) disable iff (rst)
    start_pkt |-> (len_pick >= CNT_W'(LEN_OFS)) && (len_pick <= ({1'b0, len_field} + CNT_W'(LEN_OFS))))
    else $error("picked length outside its field bound");

  assert_gap_after_eop_R6: assert property (@(posedge clk) disable iff (rst)
    o_eop |=> !o_valid)
    else $error("no idle cycle after the CRC word");
endmodule

// File: rtl/pkt_traffic_gen.sv
module pkt_traffic_gen
  import pkt_gen_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int GAP_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_en,
  input  logic              tx_start,
  input  logic              rand_len_en,
  input  logic [LEN_W-1:0]  len_field,
  input  logic              rand_gap_en,
  input  logic [GAP_W-1:0]  gap_field,
  input  logic              crc_invert_all,
  input  logic              crc_flip_lsb,
  input  logic              rx_mismatch,
  input  logic              link_pkt_err,
  input  logic              data_pkt_err,
  output logic              tx_valid,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic [DATA_W-1:0] tx_data
);
  logic [DATA_W-1:0] pay_word;
  logic [31:0]       rng_word;
  logic [31:0]       crc_word;
  logic              pay_adv, rng_adv, crc_clr, crc_adv;
  logic              err_any;

  assign err_any = rx_mismatch || link_pkt_err || data_pkt_err;

  pkt_lfsr #(.W(DATA_W), .TAPS(LFSR_TAPS), .SEED(PAY_SEED)) u_pay_lfsr (
    .clk(clk), .rst(rst), .reload(!test_en), .adv(pay_adv), .q(pay_word)
  );

  pkt_lfsr #(.W(32), .TAPS(LFSR_TAPS), .SEED(RNG_SEED)) u_rng_lfsr (
    .clk(clk), .rst(rst), .reload(!test_en), .adv(rng_adv), .q(rng_word)
  );

  pkt_crc32 u_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .adv(crc_adv), .din(pay_word), .crc_q(crc_word)
  );

  pkt_seq #(.LEN_W(LEN_W), .GAP_W(GAP_W)) u_seq (
    .clk(clk), .rst(rst), .test_en(test_en), .start(tx_start), .err_any(err_any),
    .rand_len_en(rand_len_en), .len_field(len_field),
    .rand_gap_en(rand_gap_en), .gap_field(gap_field),
    .inv_all(crc_invert_all), .flip_lsb(crc_flip_lsb),
    .pay_word(pay_word), .rng_word(rng_word), .crc_word(crc_word),
    .pay_adv(pay_adv), .rng_adv(rng_adv), .crc_clr(crc_clr), .crc_adv(crc_adv),
    .o_valid(tx_valid), .o_sop(tx_sop), .o_eop(tx_eop), .o_data(tx_data)
  );
endmodule

// File: tb/pkt_traffic_gen_test.sv
`timescale 1ns/1ps
module pkt_traffic_gen_test;
  import pkt_gen_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, test_en, tx_start, rand_len_en, rand_gap_en;
  logic [10:0] len_field;
  logic [6:0]  gap_field;
  logic        crc_invert_all, crc_flip_lsb, rx_mismatch, link_pkt_err, data_pkt_err;
  logic        tx_valid, tx_sop, tx_eop;
  logic [31:0] tx_data;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [31:0] m_pay, m_rng;

  pkt_traffic_gen uut (
    .clk(clk), .rst(rst), .test_en(test_en), .tx_start(tx_start),
    .rand_len_en(rand_len_en), .len_field(len_field),
    .rand_gap_en(rand_gap_en), .gap_field(gap_field),
    .crc_invert_all(crc_invert_all), .crc_flip_lsb(crc_flip_lsb),
    .rx_mismatch(rx_mismatch), .link_pkt_err(link_pkt_err), .data_pkt_err(data_pkt_err),
    .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_data(tx_data)
  );

  function automatic logic [31:0] m_step(input logic [31:0] s);
    return {s[30:0], 1'b0} ^ (s[31] ? 32'h0040_0007 : 32'h0);
  endfunction

  function automatic logic [31:0] m_crc(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c;
    for (int b = 0; b < 32; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ 32'hEDB8_8320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // Leaves the bench at a falling edge with test_en just raised.
  task automatic enable_fresh();
    @(negedge clk);
    test_en = 1'b0;
    @(negedge clk);
    m_pay = 32'hC0DE_0001;
    m_rng = 32'h1357_9BDF;
    test_en  = 1'b1;
    tx_start = 1'b1;
  endtask

  task automatic next_dims(output int l, output int g);
    l = rand_len_en ? int'(m_rng[10:0] & len_field) + 3 : int'(len_field) + 3;
    g = rand_gap_en ? int'(m_rng[22:16] & gap_field) + 2 : int'(gap_field) + 2;
    m_rng = m_step(m_rng);
  endtask

  task automatic check_pkt(input int l, input int g, input bit wait_sop,
                           input bit expect_next, input string req);
    logic [31:0] crc;
    logic [31:0] exp;
    bit seen;
    if (wait_sop) begin
      seen = 1'b0;
      for (int k = 0; k < 10 && !seen; k++) begin
        @(negedge clk);
        seen = tx_valid && tx_sop;
      end
      chk(seen, req, "first word marker", {31'd0, tx_sop}, 32'd1);
    end
    crc = 32'hFFFF_FFFF;
    for (int i = 0; i < l; i++) begin
      chk(tx_valid && !tx_eop && (tx_sop == (i == 0)), req, "payload framing",
          {29'd0, tx_valid, tx_sop, tx_eop}, {29'd0, 1'b1, i == 0, 1'b0});
      chk(tx_data == m_pay, "R7", "payload word", tx_data, m_pay);
      crc   = m_crc(crc, m_pay);
      m_pay = m_step(m_pay);
      @(negedge clk);
    end
    exp = ~crc;
    if (crc_invert_all) exp = ~exp;
    if (crc_flip_lsb)   exp[0] = ~exp[0];
    chk(tx_valid && tx_eop && !tx_sop, "R4", "CRC word marker",
        {29'd0, tx_valid, tx_sop, tx_eop}, 32'd5);
    chk(tx_data == exp, "R8", "CRC word value", tx_data, exp);
    @(negedge clk);
    for (int j = 0; j < g; j++) begin
      chk(!tx_valid, "R6", "idle gap", {31'd0, tx_valid}, 32'd0);
      @(negedge clk);
    end
    if (expect_next)
      chk(tx_valid && tx_sop, "R6", "next packet after gap", {31'd0, tx_sop}, 32'd1);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!tx_valid && !tx_sop && !tx_eop, "R1", "idle with test mode off",
          {29'd0, tx_valid, tx_sop, tx_eop}, 32'd0);
    end
    test_en  = 1'b1;
    tx_start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!tx_valid, "R1", "idle with start low", {31'd0, tx_valid}, 32'd0);
    end
    test_en = 1'b0;
  endtask

  task automatic t_fixed();
    int l, g;
    rand_len_en = 1'b0; rand_gap_en = 1'b0;
    len_field = 11'd5; gap_field = 7'd3;
    enable_fresh();
    for (int p = 0; p < 3; p++) begin
      next_dims(l, g);
      chk(l == 8 && g == 5, "R4", "fixed dims", l, 8);
      check_pkt(l, g, p == 0, 1'b1, "R4");
    end
    len_field = 11'd0; gap_field = 7'd0;
    enable_fresh();
    for (int p = 0; p < 2; p++) begin
      next_dims(l, g);
      check_pkt(l, g, p == 0, 1'b1, "R4");
    end
  endtask

  task automatic t_random();
    int l, g;
    rand_len_en = 1'b1; rand_gap_en = 1'b1;
    len_field = 11'h00F; gap_field = 7'h07;
    enable_fresh();
    for (int p = 0; p < 6; p++) begin
      next_dims(l, g);
      chk(l >= 3 && l <= 18, "R5", "random length bound", l, 18);
      check_pkt(l, g, p == 0, 1'b1, "R5");
    end
  endtask

  task automatic t_crc_mods();
    int l, g;
    rand_len_en = 1'b0; rand_gap_en = 1'b0;
    len_field = 11'd2; gap_field = 7'd1;
    crc_invert_all = 1'b1;
    enable_fresh();
    next_dims(l, g);
    check_pkt(l, g, 1'b1, 1'b1, "R9");
    crc_invert_all = 1'b0;
    crc_flip_lsb   = 1'b1;
    next_dims(l, g);
    check_pkt(l, g, 1'b0, 1'b1, "R10");
    crc_invert_all = 1'b1;
    next_dims(l, g);
    check_pkt(l, g, 1'b0, 1'b1, "R10");
    crc_invert_all = 1'b0;
    crc_flip_lsb   = 1'b0;
  endtask

  task automatic t_stop();
    rand_len_en = 1'b0; rand_gap_en = 1'b0;
    len_field = 11'd60; gap_field = 7'd2;
    enable_fresh();
    @(negedge clk);
    chk(tx_sop, "R2", "stream running", {31'd0, tx_sop}, 32'd1);
    repeat (4) @(negedge clk);
    tx_start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!tx_valid, "R2", "stopped by start low", {31'd0, tx_valid}, 32'd0);
    end
    enable_fresh();
    repeat (5) @(negedge clk);
    test_en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!tx_valid, "R2", "stopped by test mode low", {31'd0, tx_valid}, 32'd0);
    end
  endtask

  task automatic t_halt(input int which);
    rand_len_en = 1'b0; rand_gap_en = 1'b0;
    len_field = 11'd20; gap_field = 7'd2;
    enable_fresh();
    repeat (4) @(negedge clk);
    chk(tx_valid, "R3", "stream running before error", {31'd0, tx_valid}, 32'd1);
    if (which == 0) rx_mismatch = 1'b1;
    else if (which == 1) link_pkt_err = 1'b1;
    else data_pkt_err = 1'b1;
    @(negedge clk);
    rx_mismatch = 1'b0; link_pkt_err = 1'b0; data_pkt_err = 1'b0;
    for (int k = 0; k < 40; k++) begin
      chk(!tx_valid, "R3", "halted after error", {31'd0, tx_valid}, 32'd0);
      @(negedge clk);
    end
    tx_start = 1'b0;
    @(negedge clk);
    tx_start = 1'b1;
    @(negedge clk);
    chk(tx_valid && tx_sop, "R3", "restart after start toggle", {31'd0, tx_sop}, 32'd1);
  endtask

  task automatic t_mid_change();
    int l, g;
    rand_len_en = 1'b0; rand_gap_en = 1'b0;
    len_field = 11'd4; gap_field = 7'd0;
    enable_fresh();
    next_dims(l, g);
    fork
      check_pkt(l, g, 1'b1, 1'b1, "R11");
      begin
        repeat (4) @(negedge clk);
        len_field = 11'd1;
        gap_field = 7'd5;
      end
    join
    next_dims(l, g);
    chk(l == 4 && g == 7, "R11", "new fields used at next packet", l, 4);
    check_pkt(l, g, 1'b0, 1'b1, "R11");
  endtask

  task automatic t_reseed();
    int l, g;
    rand_len_en = 1'b1; rand_gap_en = 1'b1;
    len_field = 11'h007; gap_field = 7'h03;
    enable_fresh();
    for (int p = 0; p < 2; p++) begin
      next_dims(l, g);
      check_pkt(l, g, p == 0, 1'b1, "R12");
    end
    enable_fresh();
    @(negedge clk);
    chk(tx_sop && tx_data == 32'hC0DE_0001, "R7", "first word after re-enable",
        tx_data, 32'hC0DE_0001);
    enable_fresh();
    for (int p = 0; p < 3; p++) begin
      next_dims(l, g);
      check_pkt(l, g, p == 0, 1'b1, "R12");
    end
  endtask

  initial begin
    rst = 1'b1;
    test_en = DEF_TEST_EN; tx_start = DEF_START;
    rand_len_en = DEF_RAND_LEN; len_field = DEF_LEN;
    rand_gap_en = DEF_RAND_GAP; gap_field = DEF_GAP;
    crc_invert_all = 1'b0; crc_flip_lsb = 1'b0;
    rx_mismatch = 1'b0; link_pkt_err = 1'b0; data_pkt_err = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fixed();
    t_random();
    t_crc_mods();
    t_stop();
    t_halt(0);
    t_halt(1);
    t_halt(2);
    t_mid_change();
    t_reseed();
    finish_run();
  end
endmodule